// File: doc/BRIEF.md
# DMA Channel Sequencer with Event and Interrupt Logic

This block is the control core of one direct-memory-access channel. Once a block transfer is started, it walks a nest of three counters: bytes within an element, elements within a frame, and frames within a block. For every byte it presents a source and a destination byte address. It asks a shared port for service one element at a time. An element, once granted, is never split: all of its bytes go out on consecutive cycles while the port is held locked.

The start addresses are given as word addresses and become byte addresses by a one-bit left shift. A start that points into the reserved low word range is refused, and so is a start with a zero count. Along the way the sequencer raises several events: the final frame has begun, the first half of a frame is done, a frame is done, the block is done, a synchronisation pulse was dropped, and the port grant timed out. An enable mask decides which events are recorded in a sticky status word. That word clears when it is read. The enabled non-timeout events drive the channel interrupt, while a timeout aborts the block and drives a separate bus-error line.

In synchronised mode each element waits for a pending sync pulse. The pending flag is visible in the status word.

Top module: `dma_chan_top`

## Requirements
- R1: At start, the source and destination byte addresses equal the configured word addresses shifted left by one bit (byte address = word address × 2).
- R2: A start is refused, and busy stays low, when either word address is below 0x60 (the reserved words 0x00–0x5F) or when the element or frame count is zero.
- R3: Element size code 0, 1 and 2 selects 1, 2 and 4 bytes. Both addresses step by one per byte moved, so each element advances them by its size.
- R4: Once an element is granted, all of its bytes move on consecutive cycles with port_lock high, even if the grant is withdrawn.
- R5: A block moves frame_count × elem_count elements and then goes idle. The frame event fires at the last byte of each frame and the block event at the last byte of the block. The last-frame event fires at the first byte of the final frame.
- R6: The half event fires at the last byte of element number ceil(n/2) of a frame of n elements. For odd n, this is the first point at which more elements have moved than remain.
- R7: Status bit positions are block 0, last-frame 1, frame 2, half 3, drop 4, timeout 5, and sync-pending 6. An event sets its status bit only if its enable bit (same position) is 1. ch_irq is high in the cycle after any enabled event among bits 0–4.
- R8: Event status bits stay set until read. stat_rd shows the current status and clears bits 0–5 at the following edge, except for bits set by events in that same cycle.
- R9: In synchronised mode, no element is requested until a sync pulse is pending. Status bit 6 shows the pending flag, which clears when the element is granted.
- R10: A sync pulse that arrives while one is already pending and not being consumed raises the drop event.
- R11: If the port request goes ungranted for TOUT_CYC cycles, the block is aborted and bus_err pulses whatever the enable. Status bit 5 is set only if enabled, and ch_irq is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a block transfer |
| sync_mode | input | 1 | 1: each element waits for a sync pulse |
| sync_evt | input | 1 | Synchronisation event pulse |
| elem_size | input | 2 | Element size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes) |
| elem_count | input | CNT_W | Elements per frame |
| frame_count | input | CNT_W | Frames per block |
| src_word | input | WA_W | Source start word address |
| dst_word | input | WA_W | Destination start word address |
| evt_en | input | 6 | Event enable mask, bit positions as in R7 |
| stat_rd | input | 1 | Status read strobe, clears on read |
| port_gnt | input | 1 | Port grant |
| port_req | output | 1 | Port request for the next element |
| port_lock | output | 1 | Port held for an element in progress |
| xfer_valid | output | 1 | One byte is moved this cycle |
| src_addr | output | WA_W+1 | Current source byte address |
| dst_addr | output | WA_W+1 | Current destination byte address |
| busy | output | 1 | Block transfer in progress |
| status | output | 7 | Status word, layout in R7 |
| ch_irq | output | 1 | Channel interrupt pulse |
| bus_err | output | 1 | Bus-error pulse on timeout |

## Verification
The assertions check several rules on every cycle. A granted element keeps moving bytes without a gap. A synchronised element starts only after a pending pulse. The addresses never fall into the reserved range while busy. No status bit rises without its enable. A read leaves only same-cycle events set. A timeout leaves the channel idle. Other behaviours can only be shown by the bench's scenarios, because they depend on the configured counts: the exact byte at which the half event fires for odd and even frames, the total number of bytes and interrupts in a block, the address sequence, and the refusal of reserved or zero-count starts.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int EV_N    = 6;
    localparam int ST_W    = 7;
    localparam int RES_TOP = 96;  // first usable word address

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } esize_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_MOVE = 2'd2
    } seq_st_t;

    // packed so that bit 0 is block and bit 5 is timeout
    typedef struct packed {
        logic tout;
        logic drop;
        logic half;
        logic frame;
        logic last;
        logic block;
    } evt_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_chan_pkg::*;
#(
    parameter int WA_W     = 23,
    parameter int CNT_W    = 16,
    parameter int TOUT_CYC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sync_mode,
    input  logic             sync_evt,
    input  logic [1:0]       elem_size,
    input  logic [CNT_W-1:0] elem_count,
    input  logic [CNT_W-1:0] frame_count,
    input  logic [WA_W-1:0]  src_word,
    input  logic [WA_W-1:0]  dst_word,
    input  logic             port_gnt,
    output logic             port_req,
    output logic             port_lock,
    output logic             xfer_valid,
    output logic [WA_W:0]    src_addr,
    output logic [WA_W:0]    dst_addr,
    output logic             busy,
    output logic             sync_pend,
    output evt_t             ev
);
    localparam int BA_W = WA_W + 1;
    localparam int TC_W = $clog2(TOUT_CYC) + 1;
    localparam logic [WA_W-1:0] RES_WORD = WA_W'(RES_TOP);
    localparam logic [BA_W-1:0] RES_BYTE = BA_W'(2 * RES_TOP);

    seq_st_t          st_q;
    logic [1:0]       size_q;
    logic             sync_q;
    logic [CNT_W-1:0] el_cnt_q, fr_cnt_q;
    logic [CNT_W-1:0] elem_idx, frame_idx;
    logic [1:0]       byte_idx;
    logic [TC_W-1:0]  wait_cnt;

    logic             start_ok, grant_now, consume, tfire;
    logic             byte_last, elem_last, frame_last;
    logic [2:0]       nbytes;
    logic [CNT_W-1:0] half_pt;

    always_comb begin
        start_ok = (src_word >= RES_WORD) && (dst_word >= RES_WORD) &&
                   (elem_count != '0) && (frame_count != '0);
        nbytes     = size_bytes(size_q);
        half_pt    = CNT_W'(({1'b0, el_cnt_q} + 1'b1) >> 1);
        byte_last  = ({1'b0, byte_idx} == (nbytes - 3'd1));
        elem_last  = (elem_idx == el_cnt_q - 1'b1);
        frame_last = (frame_idx == fr_cnt_q - 1'b1);
        port_req   = (st_q == SQ_WAIT) && (!sync_q || sync_pend);
        grant_now  = port_req && port_gnt;
        consume    = grant_now && sync_q;
        tfire      = port_req && !port_gnt && (wait_cnt == TC_W'(TOUT_CYC - 1));
        xfer_valid = (st_q == SQ_MOVE);
        port_lock  = (st_q == SQ_MOVE);
        busy       = (st_q != SQ_IDLE);
    end

    always_comb begin
        ev.block = xfer_valid && byte_last && elem_last && frame_last;
        ev.frame = xfer_valid && byte_last && elem_last;
        ev.half  = xfer_valid && byte_last && ((elem_idx + 1'b1) == half_pt);
        ev.last  = xfer_valid && (byte_idx == 2'd0) && (elem_idx == '0) && frame_last;
        ev.drop  = sync_evt && sync_pend && !consume;
        ev.tout  = tfire;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_pend <= 1'b0;
        else     sync_pend <= (sync_pend && !consume) || sync_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SQ_IDLE;
            size_q    <= 2'd0;
            sync_q    <= 1'b0;
            el_cnt_q  <= '0;
            fr_cnt_q  <= '0;
            elem_idx  <= '0;
            frame_idx <= '0;
            byte_idx  <= '0;
            wait_cnt  <= '0;
            src_addr  <= '0;
            dst_addr  <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (start && start_ok) begin
                        st_q      <= SQ_WAIT;
                        size_q    <= elem_size;
                        sync_q    <= sync_mode;
                        el_cnt_q  <= elem_count;
                        fr_cnt_q  <= frame_count;
                        elem_idx  <= '0;
                        frame_idx <= '0;
                        byte_idx  <= '0;
                        wait_cnt  <= '0;
                        src_addr  <= {src_word, 1'b0};
                        dst_addr  <= {dst_word, 1'b0};
                    end
                end
                SQ_WAIT: begin
                    if (grant_now) begin
                        st_q     <= SQ_MOVE;
                        byte_idx <= '0;
                        wait_cnt <= '0;
                    end else if (tfire) begin
                        st_q     <= SQ_IDLE;
                        wait_cnt <= '0;
                    end else if (port_req) begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                SQ_MOVE: begin
                    src_addr <= src_addr + 1'b1;
                    dst_addr <= dst_addr + 1'b1;
                    if (!byte_last) begin
                        byte_idx <= byte_idx + 1'b1;
                    end else begin
                        byte_idx <= '0;
                        if (elem_last) begin
                            elem_idx <= '0;
                            if (frame_last) begin
                                st_q <= SQ_IDLE;
                            end else begin
                                frame_idx <= frame_idx + 1'b1;
                                st_q      <= SQ_WAIT;
                            end
                        end else begin
                            elem_idx <= elem_idx + 1'b1;
                            st_q     <= SQ_WAIT;
                        end
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // R4: a granted element is never split
    p_elem_atomic_r4: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !byte_last) |=> xfer_valid);

    // R9: a synchronised element starts only on a pending pulse
    p_sync_gate_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(xfer_valid) && sync_q) |-> $past(sync_pend));

    // R2: the reserved range is never addressed while busy
    p_no_reserved_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (src_addr >= RES_BYTE && dst_addr >= RES_BYTE));

    // R11: a timeout leaves the channel idle
    p_tout_abort_r11: assert property (@(posedge clk) disable iff (rst)
        ev.tout |=> !busy);

endmodule

// File: rtl/dma_evt_ctl.sv
module dma_evt_ctl
    import dma_chan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  evt_t            ev,
    input  logic [EV_N-1:0] evt_en,
    input  logic            stat_rd,
    input  logic            sync_pend,
    output logic [ST_W-1:0] status,
    output logic            ch_irq,
    output logic            bus_err
);
    localparam logic [EV_N-1:0] IRQ_MASK = EV_N'(6'b011111);

    logic [EV_N-1:0] ev_vec, hit, stat_q;

    always_comb begin
        ev_vec = ev;
        hit    = ev_vec & evt_en;
        status = {sync_pend, stat_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            ch_irq  <= 1'b0;
            bus_err <= 1'b0;
        end else begin
            stat_q  <= (stat_rd ? '0 : stat_q) | hit;
            ch_irq  <= |(hit & IRQ_MASK);
            bus_err <= ev.tout;
        end
    end

    // R7: no status bit rises without its enable
    p_status_masked_r7: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q) & ~$past(evt_en)) == '0));

    // R8: after a read only same-cycle events remain
    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        $past(stat_rd) |-> ((stat_q & ~$past(ev_vec & evt_en)) == '0));

    // R8: without a read, set bits stay set
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R11: a lone timeout never raises the channel interrupt
    p_tout_no_irq_r11: assert property (@(posedge clk) disable iff (rst)
        (ev.tout && ((ev_vec & evt_en & IRQ_MASK) == '0)) |=> !ch_irq);

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
    import dma_chan_pkg::*;
#(
    parameter int WA_W     = 23,
    parameter int CNT_W    = 16,
    parameter int TOUT_CYC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sync_mode,
    input  logic             sync_evt,
    input  logic [1:0]       elem_size,
    input  logic [CNT_W-1:0] elem_count,
    input  logic [CNT_W-1:0] frame_count,
    input  logic [WA_W-1:0]  src_word,
    input  logic [WA_W-1:0]  dst_word,
    input  logic [5:0]       evt_en,
    input  logic             stat_rd,
    input  logic             port_gnt,
    output logic             port_req,
    output logic             port_lock,
    output logic             xfer_valid,
    output logic [WA_W:0]    src_addr,
    output logic [WA_W:0]    dst_addr,
    output logic             busy,
    output logic [6:0]       status,
    output logic             ch_irq,
    output logic             bus_err
);
    evt_t ev;
    logic sync_pend;

    dma_xfer_seq #(
        .WA_W(WA_W), .CNT_W(CNT_W), .TOUT_CYC(TOUT_CYC)
    ) seq_i (
        .clk(clk), .rst(rst), .start(start),
        .sync_mode(sync_mode), .sync_evt(sync_evt),
        .elem_size(elem_size), .elem_count(elem_count),
        .frame_count(frame_count), .src_word(src_word), .dst_word(dst_word),
        .port_gnt(port_gnt), .port_req(port_req), .port_lock(port_lock),
        .xfer_valid(xfer_valid), .src_addr(src_addr), .dst_addr(dst_addr),
        .busy(busy), .sync_pend(sync_pend), .ev(ev)
    );

    dma_evt_ctl evt_i (
        .clk(clk), .rst(rst), .ev(ev), .evt_en(evt_en),
        .stat_rd(stat_rd), .sync_pend(sync_pend),
        .status(status), .ch_irq(ch_irq), .bus_err(bus_err)
    );

endmodule

// File: tb/dma_chan_top_tb_top.sv
module dma_chan_top_tb_top;
    localparam int WA_W = 23;
    localparam int CNT_W = 16;
    localparam int TOUT = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, sync_mode = 0, sync_evt = 0, stat_rd = 0, port_gnt = 0;
    logic [1:0] elem_size = 0;
    logic [CNT_W-1:0] elem_count = 0, frame_count = 0;
    logic [WA_W-1:0] src_word = 0, dst_word = 0;
    logic [5:0] evt_en = 0;
    logic port_req, port_lock, xfer_valid, busy, ch_irq, bus_err;
    logic [WA_W:0] src_addr, dst_addr;
    logic [6:0] status;

    int checks = 0, errors = 0;
    int byte_cnt, irq_cnt, berr_cnt, addr_err, lock_err, first_irq;
    logic [WA_W:0] sbase, dbase;
    bit done = 0;

    always #10 clk = ~clk;

    dma_chan_top #(.WA_W(WA_W), .CNT_W(CNT_W), .TOUT_CYC(TOUT)) dut_i (
        .clk(clk), .rst(rst), .start(start), .sync_mode(sync_mode),
        .sync_evt(sync_evt), .elem_size(elem_size), .elem_count(elem_count),
        .frame_count(frame_count), .src_word(src_word), .dst_word(dst_word),
        .evt_en(evt_en), .stat_rd(stat_rd), .port_gnt(port_gnt),
        .port_req(port_req), .port_lock(port_lock), .xfer_valid(xfer_valid),
        .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy),
        .status(status), .ch_irq(ch_irq), .bus_err(bus_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ch_irq) begin
                if (first_irq < 0) first_irq = byte_cnt;
                irq_cnt++;
            end
            if (bus_err) berr_cnt++;
            if (port_lock !== xfer_valid) lock_err++;
            if (xfer_valid) begin
                if (src_addr !== sbase + (WA_W+1)'(byte_cnt) ||
                    dst_addr !== dbase + (WA_W+1)'(byte_cnt)) addr_err++;
                byte_cnt++;
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        byte_cnt = 0; irq_cnt = 0; berr_cnt = 0; addr_err = 0;
        lock_err = 0; first_irq = -1;
    endtask

    task automatic launch(input logic [1:0] sz, input int ne, input int nf,
                          input int sw, input int dw, input logic [5:0] en,
                          input logic sm);
        @(negedge clk);
        elem_size = sz; elem_count = CNT_W'(ne); frame_count = CNT_W'(nf);
        src_word = WA_W'(sw); dst_word = WA_W'(dw); evt_en = en; sync_mode = sm;
        sbase = {src_word, 1'b0}; dbase = {dst_word, 1'b0};
        clear_mon();
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic read_stat(output logic [6:0] v);
        @(negedge clk);
        v = status;
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
    endtask

    task automatic t_reset();
        check("R7 reset status", status, 0);
        check("R7 reset irq", {ch_irq, bus_err, busy, port_req}, 0);
    endtask

    task automatic t_basic();
        logic [6:0] v;
        port_gnt = 1;
        launch(2'd1, 3, 2, 'h24000, 'h300, 6'h3F, 0);
        check("R1 src byte addr", src_addr, 'h48000);
        check("R1 dst byte addr", dst_addr, 'h600);
        wait_idle();
        check("R5 bytes in block", byte_cnt, 12);
        check("R3 address sequence", addr_err, 0);
        check("R5 irq pulses", irq_cnt, 5);
        read_stat(v);
        check("R8 status after block", v, 7'h0F);
        read_stat(v);
        check("R8 cleared by read", v, 7'h00);
        check("R4 lock follows bytes", lock_err, 0);
    endtask

    task automatic t_half(input int ne, input int exp_bytes);
        logic [6:0] v;
        port_gnt = 1;
        launch(2'd0, ne, 1, 'h100, 'h200, 6'h08, 0);
        wait_idle();
        check("R6 half point byte", first_irq, exp_bytes);
        read_stat(v);
        check("R7 only half set", v, 7'h08);
    endtask

    task automatic t_mask();
        logic [6:0] v;
        port_gnt = 1;
        launch(2'd2, 2, 3, 'h80, 'h1000, 6'h04, 0);
        wait_idle();
        check("R3 word elements", byte_cnt, 24);
        check("R3 word addresses", addr_err, 0);
        check("R7 irq per frame only", irq_cnt, 3);
        read_stat(v);
        check("R7 masked status", v, 7'h04);
    endtask

    task automatic t_atomic();
        port_gnt = 0;
        launch(2'd2, 2, 1, 'h400, 'h500, 6'h00, 0);
        while (!port_req) @(negedge clk);
        port_gnt = 1;
        @(negedge clk);
        port_gnt = 0;
        repeat (6) @(negedge clk);
        check("R4 whole element moved", byte_cnt, 4);
        check("R4 waits for next grant", port_req, 1);
        port_gnt = 1;
        wait_idle();
        check("R4 block finished", byte_cnt, 8);
        check("R4 lock during element", lock_err, 0);
    endtask

    task automatic t_sync();
        logic [6:0] v;
        port_gnt = 1;
        launch(2'd0, 2, 1, 'h700, 'h800, 6'h3F, 1);
        repeat (5) @(negedge clk);
        check("R9 no byte without sync", byte_cnt, 0);
        port_gnt = 0;
        sync_evt = 1; @(negedge clk); sync_evt = 0;
        check("R9 pending flag shown", status[6], 1);
        sync_evt = 1; @(negedge clk); sync_evt = 0;
        port_gnt = 1;
        repeat (4) @(negedge clk);
        check("R9 one element per sync", byte_cnt, 1);
        check("R9 pending cleared", status[6], 0);
        sync_evt = 1; @(negedge clk); sync_evt = 0;
        wait_idle();
        check("R9 second element", byte_cnt, 2);
        read_stat(v);
        check("R10 drop recorded", v, 7'h1F);
    endtask

    task automatic t_timeout(input logic [5:0] en, input logic [6:0] exp);
        logic [6:0] v;
        port_gnt = 0;
        launch(2'd0, 1, 1, 'h900, 'h900, en, 0);
        repeat (TOUT + 6) @(negedge clk);
        check("R11 aborted", busy, 0);
        check("R11 bus error pulse", berr_cnt, 1);
        check("R11 no channel irq", irq_cnt, 0);
        read_stat(v);
        check("R11 timeout status", v, exp);
    endtask

    task automatic t_reserved();
        port_gnt = 1;
        launch(2'd0, 1, 1, 'h5F, 'h900, 6'h00, 0);
        check("R2 reserved src refused", busy, 0);
        launch(2'd0, 1, 1, 'h900, 'h10, 6'h00, 0);
        check("R2 reserved dst refused", busy, 0);
        launch(2'd0, 0, 1, 'h900, 'h900, 6'h00, 0);
        check("R2 zero count refused", busy, 0);
        launch(2'd0, 1, 1, 'h60, 'h60, 6'h00, 0);
        check("R2 first usable word accepted", busy, 1);
        wait_idle();
        check("R2 one byte moved", byte_cnt, 1);
    endtask

    initial begin
        clear_mon();
        sbase = 0; dbase = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_half(5, 3);
        t_half(4, 2);
        t_half(1, 1);
        t_mask();
        t_atomic();
        t_sync();
        t_timeout(6'h3F, 7'h20);
        t_timeout(6'h00, 7'h00);
        t_reserved();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule